// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Code Register Front End

This block is the digital front end of a two-channel parallel-input converter. A parallel data word is written into one of two staging registers. A chip-select input qualifies the write and a channel-select bit picks the target. Each channel then has a second, output-stage code register with its own active-low load strobe. That second stage lets the two channels be updated one at a time or together, or be run single-buffered with the strobe held low. The analog conversion and the output amplifiers are not part of this block.

All control pins are brought into the system clock through two-flop synchronizers, and the level-sensitive latches are emulated with clocked registers. An active-low reset clears every register at once. Its release is synchronised to the clock. An active-low shutdown input controls only the per-channel output-enable flags, so both register stages keep loading while the outputs are disabled.

Top module: `dual_code_latch`

## Requirements
- R1: The data width `W` is a parameter, 12 by default, and 10 is also supported. Bit `W-1` of `data_i` is the most significant bit and lands in bit `W-1` of each code output.
- R2: A write with `sel_a`=1 goes to channel A's staging register, and a write with `sel_a`=0 goes to channel B's. The staging register that is not selected keeps its contents.
- R3: While `cs_n` is low, the selected staging register follows `data_i`. When `cs_n` goes high, it keeps the last value it took.
- R4: While a channel's load strobe is low, its code register takes that channel's staging register. While the strobe is high, the code register holds.
- R5: With `cs_n` high, a one-cycle low pulse on both strobes updates both code registers on the same clock edge.
- R6: While a channel's strobe is low, a write to that channel reaches its code register on the same edge that loads the staging register.
- R7: A low `rst_n` clears both staging registers, both code registers and both enable flags at once, without waiting for a clock edge, whatever the other inputs are. After release, the codes stay zero until new data is written and loaded.
- R8: While `shdn_n` is low, both enable flags are 0, and writes and loads still change the registers.
- R9: When `shdn_n` returns high, both enable flags return to 1. The codes loaded last are presented without any reload.
- R10: A change on a control or data pin takes effect at the third rising clock edge after it is applied: two synchronizer stages, then the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Asserts without a clock edge and is released in step with the clock. |
| data_i | input | W | Parallel data word, MSB at bit W-1 |
| cs_n | input | 1 | Active-low chip select for writing a staging register |
| sel_a | input | 1 | Channel select: 1 picks channel A, 0 picks channel B |
| ld_a_n | input | 1 | Active-low, level-sensitive load strobe for channel A |
| ld_b_n | input | 1 | Active-low, level-sensitive load strobe for channel B |
| shdn_n | input | 1 | Active-low shutdown, which clears the enable flags |
| code_a | output | W | Channel A output-stage code |
| code_b | output | W | Channel B output-stage code |
| en_a | output | 1 | Channel A output enable |
| en_b | output | 1 | Channel B output enable |

## Verification
The bench builds two copies of the block side by side and drives them from the same pins. One copy uses the default width of 12. The other uses a width of 10 and receives the low ten data bits. Every expected code is therefore checked at both widths, so a wrong width derivation or a misplaced MSB in either variant shows up. The 12-bit copy is the one that uses full-scale patterns such as 0xFFF and 0x800.

// File: rtl/dual_code_latch.sv
module dual_code_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_i,
  input  logic         cs_n,
  input  logic         sel_a,
  input  logic         ld_a_n,
  input  logic         ld_b_n,
  input  logic         shdn_n,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b,
  output logic         en_a,
  output logic         en_b
);
  localparam int CW = W + 5;
  localparam logic [CW-1:0] IDLE = {{W{1'b0}}, 5'b10110};

  logic [1:0]    rst_pipe;
  logic          rst_q;
  logic [CW-1:0] s1, s2;
  logic [W-1:0]  d_s, in_a, in_b, nxt_a, nxt_b;
  logic          cs_s, sel_s, lda_s, ldb_s, shdn_s, en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  assign rst_q = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_q)
    if (!rst_q) begin
      s1 <= IDLE;
      s2 <= IDLE;
    end else begin
      s1 <= {data_i, cs_n, sel_a, ld_a_n, ld_b_n, shdn_n};
      s2 <= s1;
    end

  assign {d_s, cs_s, sel_s, lda_s, ldb_s, shdn_s} = s2;

  assign nxt_a = (!cs_s && sel_s)  ? d_s : in_a;
  assign nxt_b = (!cs_s && !sel_s) ? d_s : in_b;

  always_ff @(posedge clk or negedge rst_q)
    if (!rst_q) begin
      in_a   <= '0;
      in_b   <= '0;
      code_a <= '0;
      code_b <= '0;
      en_q   <= 1'b0;
    end else begin
      in_a <= nxt_a;
      in_b <= nxt_b;
      if (!lda_s) code_a <= nxt_a;
      if (!ldb_s) code_b <= nxt_b;
      en_q <= shdn_s;
    end

  assign en_a = en_q;
  assign en_b = en_q;

  // R7
  reset_zero_chk: assert property (@(posedge clk)
    !rst_q |-> (code_a == '0 && code_b == '0 && in_a == '0 && in_b == '0 && !en_q));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cs_s |=> ($stable(in_a) && $stable(in_b)));

  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_q)
    lda_s |=> $stable(code_a));

  // R4
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ldb_s |=> $stable(code_b));

  // R6
  through_a_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!cs_s && sel_s && !lda_s) |=> (code_a == $past(d_s)));

  // R6
  through_b_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!cs_s && !sel_s && !ldb_s) |=> (code_b == $past(d_s)));

  // R8
  shdn_flag_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !shdn_s |=> (!en_a && !en_b));
endmodule

// File: tb/dual_code_latch_tb.sv
`timescale 1ns/1ps
module dual_code_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [11:0] data = '0;
  logic        cs_n = 1'b1, sel_a = 1'b0, ld_a_n = 1'b1, ld_b_n = 1'b1, shdn_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic [9:0]  c10_a, c10_b;
  logic        en_a, en_b, e10_a, e10_b;
  int          n_run = 0, n_fail = 0;
  logic [11:0] ea = '0, eb = '0;
  logic        een = 1'b0;

  always #2.5 clk = ~clk;

  dual_code_latch #(.W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .data_i(data), .cs_n(cs_n), .sel_a(sel_a),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .shdn_n(shdn_n),
    .code_a(code_a), .code_b(code_b), .en_a(en_a), .en_b(en_b));

  dual_code_latch #(.W(10)) u_dut10 (
    .clk(clk), .rst_n(rst_n), .data_i(data[9:0]), .cs_n(cs_n), .sel_a(sel_a),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .shdn_n(shdn_n),
    .code_a(c10_a), .code_b(c10_b), .en_a(e10_a), .en_b(e10_b));

  task automatic chk(input string tag);
    n_run++;
    if (code_a !== ea || code_b !== eb || en_a !== een || en_b !== een ||
        c10_a !== ea[9:0] || c10_b !== eb[9:0] || e10_a !== een || e10_b !== een) begin
      n_fail++;
      $display("FAIL %s: got a=%h b=%h en=%b%b a10=%h b10=%h en10=%b%b exp a=%h b=%h en=%b",
               tag, code_a, code_b, en_a, en_b, c10_a, c10_b, e10_a, e10_b, ea, eb, een);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic write(input logic sa, input logic [11:0] d);
    @(negedge clk);
    cs_n = 1'b0; sel_a = sa; data = d;
    @(negedge clk);
    cs_n = 1'b1; data = 12'h5A5;
  endtask

  task automatic pulse(input logic a, input logic b);
    @(negedge clk);
    ld_a_n = ~a; ld_b_n = ~b;
    @(negedge clk);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
  endtask

  task automatic t_reset_state();
    ea = '0; eb = '0; een = 1'b0;
    chk("R7 reset state");
    @(negedge clk); rst_n = 1'b1;
    repeat (8) @(negedge clk);
    een = 1'b1;
    chk("R7 zero after release");
  endtask

  task automatic t_independent();
    write(1'b1, 12'hA53);
    write(1'b0, 12'h3C7);
    settle();
    chk("R2 R3 staged writes invisible");
    pulse(1'b1, 1'b0); settle();
    ea = 12'hA53;
    chk("R4 R1 load A only");
    pulse(1'b0, 1'b1); settle();
    eb = 12'h3C7;
    chk("R2 R4 load B only");
  endtask

  task automatic t_follow();
    @(negedge clk);
    cs_n = 1'b0; sel_a = 1'b1; data = 12'h111;
    @(negedge clk); data = 12'h222;
    @(negedge clk); data = 12'hFFF;
    @(negedge clk); cs_n = 1'b1; data = 12'h0F0;
    settle();
    chk("R3 no load yet");
    pulse(1'b1, 1'b0); settle();
    ea = 12'hFFF;
    chk("R3 last value while selected kept");
  endtask

  task automatic t_simul();
    write(1'b1, 12'h800);
    write(1'b0, 12'h001);
    settle();
    @(negedge clk); ld_a_n = 1'b0; ld_b_n = 1'b0;
    @(negedge clk); ld_a_n = 1'b1; ld_b_n = 1'b1;
    @(negedge clk);
    chk("R5 R10 both unchanged before third edge");
    @(negedge clk);
    ea = 12'h800; eb = 12'h001;
    chk("R5 both updated on same edge");
  endtask

  task automatic t_through();
    @(negedge clk); ld_b_n = 1'b0;
    settle();
    @(negedge clk); cs_n = 1'b0; sel_a = 1'b0; data = 12'h6E2;
    @(negedge clk); cs_n = 1'b1;
    chk("R10 no change after one edge");
    @(negedge clk);
    chk("R10 no change after two edges");
    @(negedge clk);
    eb = 12'h6E2;
    chk("R6 R10 write-through on third edge");
    @(negedge clk); ld_b_n = 1'b1;
    settle();
    chk("R6 A untouched by B write");
  endtask

  task automatic t_rst_mid();
    @(negedge clk); ld_a_n = 1'b0; cs_n = 1'b0; sel_a = 1'b1; data = 12'hABC;
    settle(); @(negedge clk);
    ea = 12'hABC;
    chk("R6 write-through before reset");
    #0.5 rst_n = 1'b0;
    #0.5;
    ea = '0; eb = '0; een = 1'b0;
    chk("R7 async clear during write");
    @(negedge clk); cs_n = 1'b1; ld_a_n = 1'b1;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    een = 1'b1;
    chk("R7 zero after release post write");
    pulse(1'b1, 1'b1); settle();
    chk("R7 staging also cleared");
  endtask

  task automatic t_shutdown();
    @(negedge clk); shdn_n = 1'b0;
    settle();
    een = 1'b0;
    chk("R8 enables low");
    write(1'b1, 12'h39D);
    write(1'b0, 12'hC42);
    pulse(1'b1, 1'b1); settle();
    ea = 12'h39D; eb = 12'hC42;
    chk("R8 loading works in shutdown");
    @(negedge clk); shdn_n = 1'b1;
    settle();
    een = 1'b1;
    chk("R9 re-enabled with latest codes");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_independent();
    t_follow();
    t_simul();
    t_through();
    t_rst_mid();
    t_shutdown();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule